// File: doc/BRIEF.md
# Sparse Brick Lane Feeder

This block feeds several independent compute lanes from banked memory. Each bank holds a stream of fixed-width bricks. A brick is a compressed group of up to `BRICK_ELEMS` kept (value, offset) pairs, with a count of how many slots are in use. The feeder reads from memory only in whole, aligned bricks.

Each bank has a dedicated lane. Each lane then takes pairs one at a time over a valid/ready stream, at whatever rate its own sparsity allows. No lane has to wait for the others.

Software picks a slice with a start pulse, a base brick address and a length in bricks. Every bank then walks the same address range in its own memory, using its own fetch pointer. Each bank keeps one current brick and one prefetched brick. The next brick is requested while the current one is still draining, so the memory read latency is hidden.

A brick with a count of zero is discarded without producing any output. When a bank has used up its slice, its lane holds valid low and raises a done flag. The flag stays high until the next start.

Top module: `brick_feeder`

## Requirements
- R1: While reset is asserted and after it is released with no start, `mem_req`, `lane_valid` and `lane_done` are all zero.
- R2: In the cycle after the cycle where `start` is sampled high, every bank whose slice length is non-zero raises `mem_req` with `mem_addr` equal to `slice_base`, all banks together.
- R3: Each bank requests addresses `slice_base`, `slice_base+1`, and so on up to `slice_base+slice_len-1`, in that order. It makes exactly `slice_len` requests per slice.
- R4: A bank never has more than one read outstanding, and it raises no new request until the previous response has arrived. While its lane still has output pending and there is room in its two-brick buffer, the bank requests the next brick (prefetch).
- R5: Brick format on `mem_rdata`: the top `CNT_W` bits hold the kept count `c`. Pair `k` sits at bits `[k*PAIR_W +: PAIR_W]`, with the value in its low `DATA_W` bits and the offset in the `OFF_W` bits above the value. A lane emits pairs 0 to `c-1` of each brick, in brick order and then in slot order, and nothing from unused slots.
- R6: `lane_last` is high exactly on the final pair emitted from each brick.
- R7: A brick whose count is zero produces no output on its lane, and the bricks after it are still emitted in order.
- R8: Back-pressure: while `lane_valid` is high and `lane_ready` is low, the lane keeps `lane_valid` high and holds `lane_value`, `lane_offset` and `lane_last` stable.
- R9: A lane held with `lane_ready` low does not stop the other lanes from finishing their slices.
- R10: `lane_done` rises once a bank has requested, received and emitted its whole slice. While it is high, `lane_valid` is low. A new `start` clears it.
- R11: A slice length of zero issues no requests, and all lanes report done in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a new slice on every bank |
| slice_base | input | ADDR_W | First brick address of the slice |
| slice_len | input | LEN_W | Number of bricks per bank in the slice |
| mem_req | output | NUM_BANKS | Per-bank brick read request; the memory always accepts it |
| mem_addr | output | NUM_BANKS*ADDR_W | Per-bank brick address; bank b uses bits [b*ADDR_W +: ADDR_W] |
| mem_rvalid | input | NUM_BANKS | Per-bank read response strobe |
| mem_rdata | input | NUM_BANKS*BRICK_W | Per-bank brick data, format as in R5 |
| lane_valid | output | NUM_BANKS | Per-lane pair valid |
| lane_ready | input | NUM_BANKS | Per-lane consumer ready |
| lane_value | output | NUM_BANKS*DATA_W | Per-lane element value |
| lane_offset | output | NUM_BANKS*OFF_W | Per-lane element offset within its brick |
| lane_last | output | NUM_BANKS | Marks the final pair of a brick |
| lane_done | output | NUM_BANKS | Per-lane slice finished flag |

## Verification
The assertions assume three things about the environment:
- the memory returns exactly one response for each request, and only while that bank has a request outstanding;
- `start` is pulsed only when every lane is idle or done, so no response from an earlier slice is still in flight;
- `start` never coincides with a valid pair waiting on a stalled lane.

The bench models memory as a fixed two-cycle pipeline that answers each request once. It issues each new start only after every lane reports done. Its per-lane ready patterns vary freely, because the hold property only constrains the block's own outputs.

// File: rtl/brick_feeder_pkg.sv
package brick_feeder_pkg;
  localparam int DEF_BANKS  = 4;
  localparam int DEF_BRICK  = 4;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_ADDR_W = 10;
  localparam int DEF_LEN_W  = 8;

  // bits needed to hold a count from 0 to n inclusive
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bank_fetcher.sv
module bank_fetcher #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              has_room,
  input  logic              rvalid,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic              drained
);
  logic [ADDR_W-1:0] ptr;
  logic [LEN_W-1:0]  left;
  logic              pend;

  assign req     = (left != '0) && !pend && has_room && !start;
  assign addr    = ptr;
  assign drained = (left == '0) && !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      left <= '0;
      pend <= 1'b0;
    end else if (start) begin
      ptr  <= base;
      left <= len;
      pend <= 1'b0;
    end else if (req) begin
      ptr  <= ptr + 1'b1;
      left <= left - 1'b1;
      pend <= 1'b1;
    end else if (rvalid) begin
      pend <= 1'b0;
    end
  end

  AST_RESP_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> pend); // R4
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R4
endmodule

// File: rtl/brick_store.sv
module brick_store #(
  parameter int BRICK_ELEMS = 4,
  parameter int DATA_W      = 16
) (
  clk, rst_n, start, wr, wdata, ready, valid, value, offset, last, room, empty
);
  import brick_feeder_pkg::*;
  localparam int OFF_W   = (BRICK_ELEMS > 1) ? $clog2(BRICK_ELEMS) : 1;
  localparam int CNT_W   = count_width(BRICK_ELEMS);
  localparam int PAIR_W  = DATA_W + OFF_W;
  localparam int BRICK_W = CNT_W + BRICK_ELEMS * PAIR_W;

  input  logic               clk;
  input  logic               rst_n;
  input  logic               start;
  input  logic               wr;
  input  logic [BRICK_W-1:0] wdata;
  input  logic               ready;
  output logic               valid;
  output logic [DATA_W-1:0]  value;
  output logic [OFF_W-1:0]   offset;
  output logic               last;
  output logic               room;
  output logic               empty;

  logic [BRICK_W-1:0] ent [2];
  logic               head;
  logic [1:0]         occ;
  logic [OFF_W-1:0]   eidx;
  logic [BRICK_W-1:0] hbrick;
  logic [CNT_W-1:0]   hcnt;
  logic [PAIR_W-1:0]  pair;
  logic [CNT_W-1:0]   eidx_w;
  logic               tail;
  logic               pop;
  logic               adv;

  assign hbrick = ent[head];
  assign hcnt   = hbrick[BRICK_W-1 -: CNT_W];
  assign pair   = hbrick[eidx*PAIR_W +: PAIR_W];
  assign eidx_w = CNT_W'(eidx);
  assign value  = pair[DATA_W-1:0];
  assign offset = pair[DATA_W +: OFF_W];
  assign empty  = (occ == 2'd0);
  assign room   = (occ != 2'd2);
  assign valid  = !empty && (hcnt != '0);
  assign last   = valid && (eidx_w == hcnt - CNT_W'(1));
  assign pop    = !empty && ((hcnt == '0) || (valid && ready && last));
  assign adv    = valid && ready && !last;
  assign tail   = (occ == 2'd1) ? ~head : head;

  always_ff @(posedge clk) begin
    if (wr) ent[tail] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      head <= 1'b0;
      occ  <= 2'd0;
      eidx <= '0;
    end else begin
      occ <= occ + {1'b0, wr} - {1'b0, pop};
      if (pop) begin
        head <= ~head;
        eidx <= '0;
      end else if (adv) begin
        eidx <= eidx + 1'b1;
      end
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !start) |=> (valid && $stable(value) && $stable(offset) && $stable(last))); // R8
  AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    occ != 2'd3); // R4
endmodule

// File: rtl/brick_feeder.sv
module brick_feeder
  import brick_feeder_pkg::*;
#(
  parameter int NUM_BANKS   = DEF_BANKS,
  parameter int BRICK_ELEMS = DEF_BRICK,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int LEN_W       = DEF_LEN_W,
  localparam int OFF_W      = (BRICK_ELEMS > 1) ? $clog2(BRICK_ELEMS) : 1,
  localparam int CNT_W      = count_width(BRICK_ELEMS),
  localparam int PAIR_W     = DATA_W + OFF_W,
  localparam int BRICK_W    = CNT_W + BRICK_ELEMS * PAIR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [ADDR_W-1:0]              slice_base,
  input  logic [LEN_W-1:0]               slice_len,
  output logic [NUM_BANKS-1:0]           mem_req,
  output logic [NUM_BANKS*ADDR_W-1:0]    mem_addr,
  input  logic [NUM_BANKS-1:0]           mem_rvalid,
  input  logic [NUM_BANKS*BRICK_W-1:0]   mem_rdata,
  output logic [NUM_BANKS-1:0]           lane_valid,
  input  logic [NUM_BANKS-1:0]           lane_ready,
  output logic [NUM_BANKS*DATA_W-1:0]    lane_value,
  output logic [NUM_BANKS*OFF_W-1:0]     lane_offset,
  output logic [NUM_BANKS-1:0]           lane_last,
  output logic [NUM_BANKS-1:0]           lane_done
);
  logic started;

  always_ff @(posedge clk) begin
    if (!rst_n)     started <= 1'b0;
    else if (start) started <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic room;
    logic empty;
    logic drained;

    bank_fetcher #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .base     (slice_base),
      .len      (slice_len),
      .has_room (room),
      .rvalid   (mem_rvalid[b]),
      .req      (mem_req[b]),
      .addr     (mem_addr[b*ADDR_W +: ADDR_W]),
      .drained  (drained)
    );

    brick_store #(.BRICK_ELEMS(BRICK_ELEMS), .DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .wr     (mem_rvalid[b]),
      .wdata  (mem_rdata[b*BRICK_W +: BRICK_W]),
      .ready  (lane_ready[b]),
      .valid  (lane_valid[b]),
      .value  (lane_value[b*DATA_W +: DATA_W]),
      .offset (lane_offset[b*OFF_W +: OFF_W]),
      .last   (lane_last[b]),
      .room   (room),
      .empty  (empty)
    );

    assign lane_done[b] = started && drained && empty;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid[b] |-> room); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      lane_done[b] |-> !lane_valid[b]); // R10
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !lane_valid[b]); // R10
  end
endmodule

// File: tb/brick_feeder_test.sv
`timescale 1ns/1ps
module brick_feeder_test;
  localparam int NB = 4;
  localparam int BE = 4;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int LW = 8;
  localparam int OW = 2;
  localparam int CW = 3;
  localparam int PW = DW + OW;
  localparam int BW = CW + BE * PW;
  localparam int MAXE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] slice_base = '0;
  logic [LW-1:0] slice_len = '0;
  logic [NB-1:0] mem_req;
  logic [NB*AW-1:0] mem_addr;
  logic [NB-1:0] mem_rvalid;
  logic [NB*BW-1:0] mem_rdata;
  logic [NB-1:0] lane_valid;
  logic [NB-1:0] lane_ready = '0;
  logic [NB*DW-1:0] lane_value;
  logic [NB*OW-1:0] lane_offset;
  logic [NB-1:0] lane_last;
  logic [NB-1:0] lane_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  brick_feeder #(.NUM_BANKS(NB), .BRICK_ELEMS(BE), .DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .slice_base(slice_base), .slice_len(slice_len),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_value(lane_value),
    .lane_offset(lane_offset), .lane_last(lane_last), .lane_done(lane_done)
  );

  // brick contents: count (3a+b)%5, kept pairs packed from slot 0
  function automatic logic [BW-1:0] mk_brick(input int b, input int a);
    logic [BW-1:0] r;
    int c;
    c = (a * 3 + b) % 5;
    r = '0;
    r[BW-1 -: CW] = CW'(c);
    for (int k = 0; k < BE; k++) begin
      if (k < c) r[k*PW +: PW] = {OW'(BE - c + k), DW'(b * 4096 + a * 16 + k + 1)};
      else       r[k*PW +: PW] = {OW'(3), 16'hDEAD};
    end
    return r;
  endfunction

  // memory model: fixed two-cycle read latency
  logic [NB-1:0] p1v, p2v;
  logic [AW-1:0] p1a [NB];
  logic [AW-1:0] p2a [NB];
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n) begin
        p1v[b] <= 1'b0;
        p2v[b] <= 1'b0;
      end else begin
        p1v[b] <= mem_req[b];
        p2v[b] <= p1v[b];
      end
      p1a[b] <= mem_addr[b*AW +: AW];
      p2a[b] <= p1a[b];
    end
  end
  always_comb begin
    mem_rvalid = p2v;
    for (int b = 0; b < NB; b++) mem_rdata[b*BW +: BW] = mk_brick(b, int'(p2a[b]));
  end

  // ready drivers
  int rmode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    for (int b = 0; b < NB; b++) begin
      if (rmode == 0)      lane_ready[b] = 1'b1;
      else if (b == 0)     lane_ready[b] = (rmode == 2);
      else                 lane_ready[b] = ((cyc + b) % (b + 2)) != 0;
    end
  end

  // monitors
  logic [DW-1:0] got_val  [NB][MAXE];
  logic [OW-1:0] got_off  [NB][MAXE];
  logic          got_last [NB][MAXE];
  int  got_n    [NB];
  int  req_n    [NB];
  int  outst    [NB];
  int  addr_bad = 0;
  int  out_bad  = 0;
  int  hold_bad = 0;
  logic [NB-1:0] pref_seen;
  logic [NB-1:0] ph;
  logic [DW-1:0] pv [NB];
  logic [OW-1:0] po [NB];
  logic [NB-1:0] pl;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NB; b++) begin
        if (lane_valid[b] && lane_ready[b] && got_n[b] < MAXE) begin
          got_val[b][got_n[b]]  = lane_value[b*DW +: DW];
          got_off[b][got_n[b]]  = lane_offset[b*OW +: OW];
          got_last[b][got_n[b]] = lane_last[b];
          got_n[b]++;
        end
        if (mem_req[b]) begin
          if (mem_addr[b*AW +: AW] != AW'(int'(slice_base) + req_n[b])) addr_bad++;
          req_n[b]++;
          if (lane_valid[b]) pref_seen[b] = 1'b1;
        end
        if (outst[b] + int'(mem_req[b]) - int'(mem_rvalid[b]) > 1) out_bad++;
        outst[b] = outst[b] + int'(mem_req[b]) - int'(mem_rvalid[b]);
        if (ph[b] && !(lane_valid[b] && lane_value[b*DW +: DW] == pv[b] &&
                       lane_offset[b*OW +: OW] == po[b] && lane_last[b] == pl[b])) hold_bad++;
        ph[b] = lane_valid[b] && !lane_ready[b];
        pv[b] = lane_value[b*DW +: DW];
        po[b] = lane_offset[b*OW +: OW];
        pl[b] = lane_last[b];
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int b = 0; b < NB; b++) begin
      got_n[b] = 0;
      req_n[b] = 0;
      outst[b] = 0;
    end
    pref_seen = '0;
    ph = '0;
    addr_bad = 0;
    out_bad = 0;
    hold_bad = 0;
  endtask

  task automatic pulse_start(input int base, input int len);
    @(posedge clk); #1;
    clear_mon();
    slice_base = AW'(base);
    slice_len  = LW'(len);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input logic [NB-1:0] mask, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((lane_done & mask) == mask) break;
    end
  endtask

  // compare every lane's stream with the expected one (R5, R6, R7)
  task automatic compare_streams(input int base, input int len);
    for (int b = 0; b < NB; b++) begin
      int n = 0;
      int bad = 0;
      for (int a = base; a < base + len; a++) begin
        int c = (a * 3 + b) % 5;
        for (int k = 0; k < c; k++) begin
          if (n < got_n[b]) begin
            if (got_val[b][n] != DW'(b * 4096 + a * 16 + k + 1)) bad++;
            if (got_off[b][n] != OW'(BE - c + k)) bad++;
            if (got_last[b][n] != (k == c - 1)) bad++;
          end
          n++;
        end
      end
      chk(got_n[b] == n, "R7 pair count (zero bricks skipped)", got_n[b], n);
      chk(bad == 0, "R5 R6 pair contents and last marks", bad, 0);
      chk(req_n[b] == len, "R3 request count", req_n[b], len);
    end
    chk(addr_bad == 0, "R3 address order", addr_bad, 0);
    chk(out_bad == 0, "R4 single outstanding read", out_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_req == '0, "R1 req after reset", int'(mem_req), 0);
    chk(lane_valid == '0, "R1 valid after reset", int'(lane_valid), 0);
    chk(lane_done == '0, "R1 done after reset", int'(lane_done), 0);
  endtask

  task automatic t_full_run();
    rmode = 0;
    pulse_start(5, 6);
    @(negedge clk);
    chk(mem_req == '1, "R2 all banks request together", int'(mem_req), 15);
    for (int b = 0; b < NB; b++)
      chk(mem_addr[b*AW +: AW] == AW'(5), "R2 first address", int'(mem_addr[b*AW +: AW]), 5);
    wait_done('1, 500);
    chk(lane_done == '1, "R10 done after slice", int'(lane_done), 15);
    chk(lane_valid == '0, "R10 valid low while done", int'(lane_valid), 0);
    chk(pref_seen != '0, "R4 prefetch while lane busy", int'(pref_seen), 1);
    compare_streams(5, 6);
  endtask

  task automatic t_backpressure();
    rmode = 1;
    pulse_start(20, 8);
    @(negedge clk);
    chk(lane_done == '0, "R10 start clears done", int'(lane_done), 0);
    wait_done(4'b1110, 1000);
    chk(lane_done[3:1] == 3'b111, "R9 other lanes finish", int'(lane_done[3:1]), 7);
    chk(lane_done[0] == 1'b0 && lane_valid[0], "R9 stalled lane still pending",
        int'(lane_done[0]), 0);
    rmode = 2;
    wait_done('1, 1000);
    chk(hold_bad == 0, "R8 hold under stall", hold_bad, 0);
    compare_streams(20, 8);
    rmode = 0;
  endtask

  task automatic t_zero_len();
    int seen = 0;
    pulse_start(40, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req != '0) seen++;
      if (i == 0) chk(lane_done == '1, "R11 done right after start", int'(lane_done), 15);
    end
    chk(seen == 0, "R11 no requests for empty slice", seen, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_full_run();
    t_backpressure();
    t_zero_len();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule